// File: doc/BRIEF.md
# Internal Data Memory and Register Space

This block holds the 256-byte internal data RAM of an 8051-compatible core and routes byte and bit accesses between that RAM and an external special function register (SFR) bus. The core drives three access ports at once: a direct-mode byte port, an indirect-mode byte port and a bit port. Addresses 0x80 to 0xFF mean different storage depending on the port. The direct port reaches the SFRs there, while the indirect port reaches the upper half of general RAM.

The direct port can also name a working register R0 to R7. The block resolves it into the active bank using the two bank-select bits of the program status word. The bit port addresses 256 bits. The lower half covers the sixteen bit-addressable RAM bytes and the upper half covers the SFRs whose address ends in 0x0 or 0x8. A bit set or clear merges the new bit into its byte within a single cycle. For an SFR target this is one read and one write of the merged byte on the SFR bus in the same cycle. Byte and bit reads return one cycle after the address is presented.

Top module: `idata_space`

## Requirements
- R1: A direct access with `dir_rsel`=0 and address 0x00-0x7F reads and writes RAM. `dir_rdata` shows the byte one cycle after the address is presented. A read in the same cycle as a write to that byte returns the value held before the write.
- R2: A direct access with `dir_rsel`=0 and address 0x80-0xFF goes to the SFR bus and never to RAM. `sfr_addr` equals the address. `sfr_we` and `sfr_wdata` follow the write request in the same cycle. `dir_rdata` returns the `sfr_rdata` of that cycle one cycle later.
- R3: The indirect port reaches all 256 RAM bytes, including 0x80-0xFF, and never drives a write on the SFR bus. `ind_rdata` has one cycle of latency.
- R4: With `dir_rsel`=1 the direct port accesses RAM byte {2'b00, psw_in[4:3], dir_addr[2:0]}. The other bits of `dir_addr` and `psw_in` have no effect, and the SFR bus is not written.
- R5: Bit addresses 0x00-0x7F select bit (addr mod 8) of RAM byte 0x20 + (addr >> 3). `bit_set` writes 1 and `bit_clr` writes 0, and the other seven bits keep their values. `bit_rdata` returns the addressed bit one cycle later.
- R6: Bit addresses 0x80-0xFF select bit (addr mod 8) of SFR byte (addr AND 0xF8). A set or clear drives that byte address on the SFR bus, reads `sfr_rdata` and asserts `sfr_we` in the same cycle. `sfr_wdata` differs from `sfr_rdata` only in the addressed bit.
- R7: When `bit_set` and `bit_clr` are both high, the addressed bit is cleared.
- R8: When several ports write the same RAM byte in one cycle, the direct port wins over the bit port, and the bit port wins over the indirect port. A winning bit write stores the old byte with only the addressed bit changed.
- R9: A direct access with `dir_rsel`=0 and address 0x80-0xFF owns the SFR bus for its cycle. A bit operation on an SFR in that cycle writes nothing, and its `bit_rdata` returns 0.
- R10: While `rst` is high, `dir_rdata`, `ind_rdata` and `bit_rdata` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_addr | input | 8 | Direct-mode byte address, or register number in bits 2:0 |
| dir_rsel | input | 1 | Treat the direct access as working register dir_addr[2:0] |
| dir_wdata | input | 8 | Direct-mode write data |
| dir_we | input | 1 | Direct-mode write enable |
| dir_rdata | output | 8 | Direct-mode read data, one cycle latency |
| ind_addr | input | 8 | Indirect-mode byte address |
| ind_wdata | input | 8 | Indirect-mode write data |
| ind_we | input | 1 | Indirect-mode write enable |
| ind_rdata | output | 8 | Indirect-mode read data, one cycle latency |
| bit_addr | input | 8 | Bit address |
| bit_set | input | 1 | Set the addressed bit |
| bit_clr | input | 1 | Clear the addressed bit |
| bit_rdata | output | 1 | Addressed bit value, one cycle latency |
| psw_in | input | 8 | Program status word; bits 4:3 select the register bank |
| sfr_addr | output | 8 | SFR bus address |
| sfr_wdata | output | 8 | SFR bus write data |
| sfr_we | output | 1 | SFR bus write strobe |
| sfr_rdata | input | 8 | SFR bus read data, combinational from sfr_addr |

## Verification
The bench targets the split of the upper 128 addresses. It fills upper RAM through the indirect port and the SFRs through the direct port, then reads each back through the other port. A design that ignored the addressing mode would show SFR values in RAM, or the reverse. Sweeps over every bit address in both halves check the mapping to bytes. Neighbouring RAM bytes are read back as well, so an off-by-one base, a wrong shift, or a merge that disturbs other bits is caught. Same-cycle collisions are also exercised: direct against indirect, bit against indirect, direct against bit, set with clear, and a direct SFR access against a bit SFR operation. A wrong priority leaves the losing value in the byte, or the blocked SFR bit is changed.

// File: rtl/idata_pkg.sv
package idata_pkg;
  localparam int unsigned ADDR_W      = 8;
  localparam int unsigned DATA_W      = 8;
  localparam int unsigned BANK_W      = 2;
  localparam int unsigned REG_IDX_W   = 3;
  localparam int unsigned PSW_W       = 8;
  localparam int unsigned BANK_LSB    = 3;
  localparam int unsigned BITRAM_BASE = 32'h20;
endpackage

// File: rtl/idata_dir_route.sv
module idata_dir_route #(
  parameter int unsigned AW     = idata_pkg::ADDR_W,
  parameter int unsigned BANK_W = idata_pkg::BANK_W,
  parameter int unsigned RIDX_W = idata_pkg::REG_IDX_W
) (
  input  logic [AW-1:0]     addr,
  input  logic              rsel,
  input  logic [BANK_W-1:0] bank,
  output logic [AW-1:0]     eff_addr,
  output logic              is_sfr
);
  localparam int unsigned PAD_W = AW - BANK_W - RIDX_W;

  always_comb begin
    if (rsel) begin
      eff_addr = {{PAD_W{1'b0}}, bank, addr[RIDX_W-1:0]};
      is_sfr   = 1'b0;
    end else begin
      eff_addr = addr;
      is_sfr   = addr[AW-1];
    end
  end
endmodule

// File: rtl/idata_bit_unit.sv
module idata_bit_unit #(
  parameter int unsigned AW   = idata_pkg::ADDR_W,
  parameter int unsigned DW   = idata_pkg::DATA_W,
  parameter int unsigned BASE = idata_pkg::BITRAM_BASE
) (
  input  logic [AW-1:0] bit_addr,
  input  logic          set_req,
  input  logic          clr_req,
  input  logic [DW-1:0] byte_in,
  output logic [AW-1:0] byte_addr,
  output logic          is_sfr,
  output logic          wr,
  output logic          bit_val,
  output logic [DW-1:0] merged
);
  localparam int unsigned IDX_W = $clog2(DW);
  localparam int unsigned SEL_W = AW - 1 - IDX_W;
  localparam logic [AW-1:0] BASE_A = AW'(BASE);

  logic [IDX_W-1:0] idx;
  logic             new_val;

  assign idx     = bit_addr[IDX_W-1:0];
  assign is_sfr  = bit_addr[AW-1];
  assign wr      = set_req | clr_req;
  assign new_val = ~clr_req;
  assign bit_val = byte_in[idx];

  always_comb begin
    if (is_sfr) byte_addr = {bit_addr[AW-1:IDX_W], {IDX_W{1'b0}}};
    else        byte_addr = BASE_A + {{(AW-SEL_W){1'b0}}, bit_addr[AW-2:IDX_W]};
  end

  for (genvar i = 0; i < DW; i++) begin : g_merge
    assign merged[i] = (wr && (idx == IDX_W'(i))) ? new_val : byte_in[i];
  end
endmodule

// File: rtl/idata_ram.sv
module idata_ram #(
  parameter int unsigned AW = idata_pkg::ADDR_W,
  parameter int unsigned DW = idata_pkg::DATA_W
) (
  input  logic          clk,
  input  logic          we_hi,
  input  logic [AW-1:0] wa_hi,
  input  logic [DW-1:0] wd_hi,
  input  logic          we_mid,
  input  logic [AW-1:0] wa_mid,
  input  logic [DW-1:0] wd_mid,
  input  logic          we_lo,
  input  logic [AW-1:0] wa_lo,
  input  logic [DW-1:0] wd_lo,
  input  logic [AW-1:0] ra_0,
  input  logic [AW-1:0] ra_1,
  input  logic [AW-1:0] ra_2,
  output logic [DW-1:0] rd_0,
  output logic [DW-1:0] rd_1,
  output logic [DW-1:0] rd_2
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // later statements override earlier ones: hi > mid > lo
  always_ff @(posedge clk) begin
    if (we_lo)  mem[wa_lo]  <= wd_lo;
    if (we_mid) mem[wa_mid] <= wd_mid;
    if (we_hi)  mem[wa_hi]  <= wd_hi;
  end

  assign rd_0 = mem[ra_0];
  assign rd_1 = mem[ra_1];
  assign rd_2 = mem[ra_2];
endmodule

// File: rtl/idata_space.sv
module idata_space #(
  parameter int unsigned AW       = idata_pkg::ADDR_W,
  parameter int unsigned DW       = idata_pkg::DATA_W,
  parameter int unsigned PSW_W    = idata_pkg::PSW_W,
  parameter int unsigned BANK_LSB = idata_pkg::BANK_LSB
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] dir_addr,
  input  logic          dir_rsel,
  input  logic [DW-1:0] dir_wdata,
  input  logic          dir_we,
  output logic [DW-1:0] dir_rdata,
  input  logic [AW-1:0] ind_addr,
  input  logic [DW-1:0] ind_wdata,
  input  logic          ind_we,
  output logic [DW-1:0] ind_rdata,
  input  logic [AW-1:0] bit_addr,
  input  logic          bit_set,
  input  logic          bit_clr,
  output logic          bit_rdata,
  input  logic [PSW_W-1:0] psw_in,
  output logic [AW-1:0] sfr_addr,
  output logic [DW-1:0] sfr_wdata,
  output logic          sfr_we,
  input  logic [DW-1:0] sfr_rdata
);
  localparam int unsigned BANK_W = idata_pkg::BANK_W;

  logic [BANK_W-1:0] bank;
  logic [AW-1:0]     dir_eff;
  logic              dir_sfr;
  logic [AW-1:0]     bit_byte;
  logic              bit_sfr;
  logic              bit_wr;
  logic              bit_val;
  logic [DW-1:0]     bit_merged;
  logic [DW-1:0]     bit_src;
  logic              bit_blocked;
  logic [DW-1:0]     ram_dir;
  logic [DW-1:0]     ram_ind;
  logic [DW-1:0]     ram_bit;

  assign bank = psw_in[BANK_LSB +: BANK_W];

  idata_dir_route #(.AW(AW), .BANK_W(BANK_W)) u_route (
    .addr(dir_addr), .rsel(dir_rsel), .bank(bank),
    .eff_addr(dir_eff), .is_sfr(dir_sfr)
  );

  assign bit_src     = bit_sfr ? sfr_rdata : ram_bit;
  assign bit_blocked = bit_sfr & dir_sfr;

  idata_bit_unit #(.AW(AW), .DW(DW)) u_bit (
    .bit_addr(bit_addr), .set_req(bit_set), .clr_req(bit_clr),
    .byte_in(bit_src), .byte_addr(bit_byte), .is_sfr(bit_sfr),
    .wr(bit_wr), .bit_val(bit_val), .merged(bit_merged)
  );

  idata_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk),
    .we_hi(dir_we & ~dir_sfr),   .wa_hi(dir_eff),   .wd_hi(dir_wdata),
    .we_mid(bit_wr & ~bit_sfr),  .wa_mid(bit_byte), .wd_mid(bit_merged),
    .we_lo(ind_we),              .wa_lo(ind_addr),  .wd_lo(ind_wdata),
    .ra_0(dir_eff), .ra_1(ind_addr), .ra_2(bit_byte),
    .rd_0(ram_dir), .rd_1(ram_ind), .rd_2(ram_bit)
  );

  // SFR bus: direct port owns it whenever it addresses the SFR space
  always_comb begin
    if (dir_sfr) begin
      sfr_addr  = dir_eff;
      sfr_wdata = dir_wdata;
      sfr_we    = dir_we;
    end else begin
      sfr_addr  = bit_byte;
      sfr_wdata = bit_merged;
      sfr_we    = bit_wr & bit_sfr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_rdata <= '0;
      ind_rdata <= '0;
      bit_rdata <= 1'b0;
    end else begin
      dir_rdata <= dir_sfr ? sfr_rdata : ram_dir;
      ind_rdata <= ram_ind;
      bit_rdata <= bit_blocked ? 1'b0 : bit_val;
    end
  end
endmodule

// File: rtl/idata_space_chk.sv
module idata_space_chk #(
  parameter int unsigned AW = idata_pkg::ADDR_W,
  parameter int unsigned DW = idata_pkg::DATA_W
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] dir_addr,
  input logic          dir_rsel,
  input logic [DW-1:0] dir_wdata,
  input logic          dir_we,
  input logic [DW-1:0] dir_rdata,
  input logic [DW-1:0] ind_rdata,
  input logic [AW-1:0] bit_addr,
  input logic          bit_set,
  input logic          bit_clr,
  input logic          bit_rdata,
  input logic [AW-1:0] sfr_addr,
  input logic [DW-1:0] sfr_wdata,
  input logic          sfr_we,
  input logic [DW-1:0] sfr_rdata
);
  localparam int unsigned IDX_W = $clog2(DW);

  logic          past_ok = 1'b0;
  logic          prev_rst = 1'b0;
  logic          dir_own;
  logic          bit_sfr_op;
  logic [DW-1:0] mask;

  always_ff @(posedge clk) begin
    past_ok  <= ~rst;
    prev_rst <= rst;
  end

  assign dir_own    = dir_addr[AW-1] & ~dir_rsel;
  assign bit_sfr_op = (bit_set | bit_clr) & bit_addr[AW-1];
  assign mask       = DW'(1) << bit_addr[IDX_W-1:0];

  a_r2_dir_sfr_bus: assert property (@(posedge clk) disable iff (rst)
    dir_own |-> (sfr_addr == dir_addr) && (sfr_we == dir_we) && (!dir_we || sfr_wdata == dir_wdata));

  a_r2_dir_sfr_read: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(dir_own)) |-> dir_rdata == $past(sfr_rdata));

  a_r3_sfr_we_source: assert property (@(posedge clk) disable iff (rst)
    sfr_we |-> (dir_own && dir_we) || (bit_sfr_op && !dir_own));

  a_r6_bit_sfr_target: assert property (@(posedge clk) disable iff (rst)
    (bit_sfr_op && !dir_own) |-> sfr_we && sfr_addr == {bit_addr[AW-1:IDX_W], {IDX_W{1'b0}}});

  a_r6_merge_keeps_others: assert property (@(posedge clk) disable iff (rst)
    (bit_sfr_op && !dir_own) |-> ((sfr_wdata ^ sfr_rdata) & ~mask) == '0);

  a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (bit_sfr_op && !dir_own && bit_clr) |-> (sfr_wdata & mask) == '0);

  a_r9_bit_blocked: assert property (@(posedge clk) disable iff (rst)
    (bit_sfr_op && dir_own) |=> !bit_rdata);

  a_r10_reset_clears: assert property (@(posedge clk)
    prev_rst |-> (dir_rdata == '0) && (ind_rdata == '0) && !bit_rdata);
endmodule

bind idata_space idata_space_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/test_idata_space.sv
`timescale 1ns/1ps
module test_idata_space;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] dir_addr, dir_wdata, dir_rdata;
  logic       dir_rsel, dir_we;
  logic [7:0] ind_addr, ind_wdata, ind_rdata;
  logic       ind_we;
  logic [7:0] bit_addr;
  logic       bit_set, bit_clr, bit_rdata;
  logic [7:0] psw_in;
  logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;
  logic       sfr_we;

  logic [7:0] sfr_mem [256];
  logic [7:0] exp_ram [256];
  logic [7:0] exp_sfr [256];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  idata_space i_idata_space (
    .clk(clk), .rst(rst),
    .dir_addr(dir_addr), .dir_rsel(dir_rsel), .dir_wdata(dir_wdata), .dir_we(dir_we), .dir_rdata(dir_rdata),
    .ind_addr(ind_addr), .ind_wdata(ind_wdata), .ind_we(ind_we), .ind_rdata(ind_rdata),
    .bit_addr(bit_addr), .bit_set(bit_set), .bit_clr(bit_clr), .bit_rdata(bit_rdata),
    .psw_in(psw_in),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_we(sfr_we), .sfr_rdata(sfr_rdata)
  );

  // peripheral model behind the SFR bus
  assign sfr_rdata = sfr_mem[sfr_addr];
  always @(posedge clk) begin
    if (rst) begin
      for (int a = 0; a < 256; a++) sfr_mem[a] <= 8'(a) ^ 8'hC3;
    end else if (sfr_we) begin
      sfr_mem[sfr_addr] <= sfr_wdata;
    end
  end

  task automatic chk8(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic chk1(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    dir_addr = 8'h00; dir_rsel = 1'b0; dir_wdata = 8'h00; dir_we = 1'b0;
    ind_addr = 8'h00; ind_wdata = 8'h00; ind_we = 1'b0;
    bit_addr = 8'h00; bit_set = 1'b0; bit_clr = 1'b0;
  endtask

  task automatic ind_chk(string tag, int a);
    idle(); ind_addr = 8'(a); step();
    chk8(tag, ind_rdata, exp_ram[a]);
  endtask

  task automatic dir_chk(string tag, int a, logic [7:0] exp);
    idle(); dir_addr = 8'(a); step();
    chk8(tag, dir_rdata, exp);
  endtask

  function automatic logic exp_bit(int b);
    if (b < 128) return exp_ram[32 + (b >> 3)][b % 8];
    return exp_sfr[b & 8'hF8][b % 8];
  endfunction

  task automatic model_bit(int b, logic v);
    if (b < 128) exp_ram[32 + (b >> 3)][b % 8] = v;
    else         exp_sfr[b & 8'hF8][b % 8] = v;
  endtask

  task automatic bit_op(int b, logic s, logic c);
    idle(); bit_addr = 8'(b); bit_set = s; bit_clr = c; step();
    model_bit(b, ~c);
    idle();
  endtask

  task automatic bit_chk(string tag, int b);
    idle(); bit_addr = 8'(b); step();
    chk1(tag, bit_rdata, exp_bit(b));
  endtask

  initial begin
    for (int a = 0; a < 256; a++) exp_sfr[a] = 8'(a) ^ 8'hC3;
    rst = 1'b1; psw_in = 8'h00; idle();
    repeat (3) step();
    chk8("R10 dir_rdata in reset", dir_rdata, 8'h00);
    chk8("R10 ind_rdata in reset", ind_rdata, 8'h00);
    chk1("R10 bit_rdata in reset", bit_rdata, 1'b0);
    rst = 1'b0;

    // R3: indirect port covers all 256 bytes, upper half is RAM
    for (int a = 0; a < 256; a++) begin
      idle(); ind_addr = 8'(a); ind_wdata = 8'(a * 7 + 3) ^ 8'h5A; ind_we = 1'b1; step();
      exp_ram[a] = 8'(a * 7 + 3) ^ 8'h5A;
      checks++;
      if (sfr_we) begin failures++; $display("FAIL R3 sfr_we on indirect write got=1 exp=0"); end
    end
    for (int a = 0; a < 256; a++) ind_chk("R3 indirect readback", a);
    for (int a = 128; a < 256; a++) chk8("R3 SFR untouched by indirect", sfr_mem[a], exp_sfr[a]);

    // R1: direct lower half is RAM
    for (int a = 0; a < 128; a++) dir_chk("R1 direct read lower", a, exp_ram[a]);
    for (int a = 0; a < 128; a++) begin
      idle(); dir_addr = 8'(a); dir_wdata = 8'(a * 11) ^ 8'h96; dir_we = 1'b1; step();
      chk8("R1 read during write old value", dir_rdata, exp_ram[a]);
      exp_ram[a] = 8'(a * 11) ^ 8'h96;
    end
    for (int a = 0; a < 256; a++) ind_chk("R1 RAM after direct writes", a);

    // R2: direct upper half is the SFR bus
    for (int a = 128; a < 256; a++) dir_chk("R2 direct SFR read", a, exp_sfr[a]);
    for (int a = 128; a < 256; a++) begin
      idle(); dir_addr = 8'(a); dir_wdata = 8'(a * 5 + 1); dir_we = 1'b1; step();
      exp_sfr[a] = 8'(a * 5 + 1);
    end
    for (int a = 128; a < 256; a++) dir_chk("R2 direct SFR readback", a, exp_sfr[a]);
    for (int a = 128; a < 256; a++) ind_chk("R2 upper RAM unchanged", a);

    // R4: working registers in each bank
    for (int bk = 0; bk < 4; bk++) begin
      for (int n = 0; n < 8; n++) begin
        idle(); psw_in = {3'b101, 2'(bk), 3'b010};
        dir_rsel = 1'b1; dir_addr = {5'b10110, 3'(n)}; dir_wdata = 8'(bk * 40 + n * 3 + 9); dir_we = 1'b1; step();
        exp_ram[bk * 8 + n] = 8'(bk * 40 + n * 3 + 9);
        chk8("R4 no SFR write for register", sfr_mem[{5'b10110, 3'(n)}], exp_sfr[{5'b10110, 3'(n)}]);
      end
    end
    for (int bk = 0; bk < 4; bk++) begin
      for (int n = 0; n < 8; n++) begin
        idle(); psw_in = {3'b010, 2'(bk), 3'b101};
        dir_rsel = 1'b1; dir_addr = {5'b01001, 3'(n)}; step();
        chk8("R4 register read in bank", dir_rdata, exp_ram[bk * 8 + n]);
      end
    end
    psw_in = 8'h00;
    for (int a = 0; a < 48; a++) ind_chk("R4 RAM after register writes", a);

    // R5: bit space over RAM bytes 0x20-0x2F
    for (int b = 0; b < 128; b++) begin
      logic v;
      v = 1'(((b * 13 + 7) >> 2) & 1);
      bit_op(b, v, ~v);
    end
    for (int a = 24; a < 56; a++) ind_chk("R5 bit area bytes and neighbours", a);
    for (int b = 0; b < 128; b++) bit_chk("R5 bit read RAM", b);

    // R6: bit space over SFR bytes ending in 0 or 8
    for (int b = 128; b < 256; b += 3) begin
      logic v;
      v = 1'(b >> 3) ^ 1'(b);
      bit_op(b, v, ~v);
    end
    for (int a = 128; a < 256; a++) dir_chk("R6 SFR bytes after bit ops", a, exp_sfr[a]);
    for (int b = 128; b < 256; b++) bit_chk("R6 bit read SFR", b);

    // R7: set and clear together clears
    bit_op(8'h4A, 1'b1, 1'b0);
    bit_op(8'h4A, 1'b1, 1'b1);
    bit_chk("R7 RAM bit cleared", 8'h4A);
    ind_chk("R7 RAM byte", 8'h29);
    bit_op(8'hC3, 1'b1, 1'b0);
    bit_op(8'hC3, 1'b1, 1'b1);
    dir_chk("R7 SFR byte", 8'hC0, exp_sfr[8'hC0]);

    // R8: same-cycle write priority
    idle(); dir_addr = 8'h40; dir_wdata = 8'h11; dir_we = 1'b1;
    ind_addr = 8'h40; ind_wdata = 8'h22; ind_we = 1'b1; step();
    exp_ram[8'h40] = 8'h11;
    ind_chk("R8 direct beats indirect", 8'h40);
    idle(); bit_addr = 8'h0D; bit_set = 1'b1;
    ind_addr = 8'h21; ind_wdata = 8'h00; ind_we = 1'b1; step();
    exp_ram[8'h21] = exp_ram[8'h21] | 8'h20;
    ind_chk("R8 bit beats indirect", 8'h21);
    idle(); dir_addr = 8'h22; dir_wdata = 8'h00; dir_we = 1'b1;
    bit_addr = 8'h10; bit_set = 1'b1; step();
    exp_ram[8'h22] = 8'h00;
    ind_chk("R8 direct beats bit", 8'h22);

    // R9: direct SFR access owns the bus
    bit_op(8'h88, 1'b0, 1'b1);
    idle(); dir_addr = 8'h90; bit_addr = 8'h88; bit_set = 1'b1; step();
    chk8("R9 direct read during bit op", dir_rdata, exp_sfr[8'h90]);
    chk1("R9 blocked bit read is zero", bit_rdata, 1'b0);
    dir_chk("R9 blocked SFR bit unchanged", 8'h88, exp_sfr[8'h88]);
    bit_op(8'h81, 1'b1, 1'b0);
    idle(); dir_addr = 8'hA0; dir_wdata = 8'h3C; dir_we = 1'b1;
    bit_addr = 8'h81; bit_clr = 1'b1; step();
    exp_sfr[8'hA0] = 8'h3C;
    dir_chk("R9 direct write wins bus", 8'hA0, exp_sfr[8'hA0]);
    dir_chk("R9 blocked clear no effect", 8'h80, exp_sfr[8'h80]);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule